// File: doc/BRIEF.md
# Multi-cycle ALU instruction sequencer

This block runs arithmetic and logic instructions one step at a time. Each instruction goes through the same fixed sequence. The program counter addresses a synchronous ROM, and the returned 16-bit word is latched. The operands are then read from an eight-entry register file. The second operand is either another register or a sign-extended 4-bit constant. The result and its flags are computed and the condition codes are committed. The result is written to the destination register, and finally the program counter advances. Any opcode outside the five supported operations stops the machine. The machine then raises an error flag and waits for reset.

Debug taps show the program counter and the condition codes. A combinational read port shows any register chosen by a select input. This makes the architectural state visible without stopping the sequencer.

Top module: `alu_seq`

## Requirements
- R1: Instruction fields are: bits [15:12] opcode (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR), [11:9] destination, [8:6] first source, bit 5 immediate select, bit 4 carry-use, [3:0] immediate or, in register form, second source in [2:0] with bit 3 ignored.
- R2: With bit 5 set, the second operand is bits [3:0] sign-extended to 16 bits. With bit 5 clear, it is the register named by bits [2:0].
- R3: ADD produces A + B + cin, where cin is the stored carry flag when bit 4 is set and 0 otherwise. C is the carry out. V is set when A and B have equal signs and the result's sign differs from A's.
- R4: SUB produces A + ~B + cin, where cin is the stored carry flag when bit 4 is set and 1 otherwise. C is the carry out, meaning no borrow. V is set when A and B have different signs and the result's sign differs from A's.
- R5: AND, OR and XOR clear C and V. Bit 4 has no effect on them.
- R6: The condition-code output is {C,V,Z,S} in bits [3:0]. Z is set when the result is zero, and S is result bit 15. All four flags are rewritten by every executed instruction.
- R7: The result is stored in the destination register. The register file holds 8 registers of 16 bits.
- R8: Each legal instruction takes exactly 7 clock cycles. The program counter rises by exactly 1 per instruction. By the time it changes, the flags and the destination register already hold that instruction's results.
- R9: An illegal opcode (5 to 15) raises `illegal` permanently until reset. From then on the program counter, flags and registers stay frozen.
- R10: Reset (active low, asynchronous) clears the program counter, flags and all registers. Execution then starts by fetching from address 0.
- R11: `romAddr` equals the program counter. The ROM word is expected one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| romAddr | output | PC_W | Instruction ROM address |
| romData | input | 16 | Instruction word from synchronous ROM |
| illegal | output | 1 | Halted on an unsupported opcode |
| dbgPc | output | PC_W | Program counter tap |
| dbgCcr | output | 4 | Condition codes {C,V,Z,S} |
| dbgRegSel | input | 3 | Register index for the debug read |
| dbgRegData | output | DATA_W | Contents of the selected register |

## Verification
A wrong sequencer state shows up at once as a program-counter step that breaks the 7-cycle rhythm, or as flags changing outside their commit step. A wrong datapath value appears within one instruction. It shows as a flag mismatch at the moment the program counter advances, or as a wrong destination register read through the debug port. Because later instructions consume earlier results, a single bad operand selection or carry-in choice propagates and is caught again by the final full register comparison.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;
  localparam int INSTR_W = 16;
  localparam int CCR_C = 3;
  localparam int CCR_V = 2;
  localparam int CCR_Z = 1;
  localparam int CCR_S = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4
  } opcode_e;

  typedef struct packed {
    logic loadIr;
    logic loadOps;
    logic loadRes;
    logic writeCcr;
    logic writeReg;
    logic incPc;
  } strobes_t;

  function automatic logic isAluOp(input logic [3:0] op);
    return op <= 4'd4;
  endfunction
endpackage

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl
  import alu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] fetchedOp,
  output strobes_t   strb,
  output logic       illegal
);
  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_READ, S_ALU, S_FLAGS, S_WRITE, S_INCR, S_HALT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    unique case (state)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        strb.loadIr = 1'b1;
        nextState = isAluOp(fetchedOp) ? S_READ : S_HALT;
      end
      S_READ:   begin strb.loadOps  = 1'b1; nextState = S_ALU;   end
      S_ALU:    begin strb.loadRes  = 1'b1; nextState = S_FLAGS; end
      S_FLAGS:  begin strb.writeCcr = 1'b1; nextState = S_WRITE; end
      S_WRITE:  begin strb.writeReg = 1'b1; nextState = S_INCR;  end
      S_INCR:   begin strb.incPc    = 1'b1; nextState = S_FETCH; end
      S_HALT:   nextState = S_HALT;
      default:  nextState = S_FETCH;
    endcase
  end

  assign illegal = (state == S_HALT);
endmodule

// File: rtl/alu_seq_alu.sv
module alu_seq_alu
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic [3:0]        flags
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sum;
  logic              carry, ovf;

  always_comb begin
    bEff  = (opcode_e'(op) == OP_SUB) ? ~b : b;
    sum   = {1'b0, a} + {1'b0, bEff} + {{DATA_W{1'b0}}, cin};
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    case (opcode_e'(op))
      OP_ADD, OP_SUB: begin
        res   = sum[DATA_W-1:0];
        carry = sum[DATA_W];
        ovf   = (a[MSB] == bEff[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      default: res = '0;
    endcase
    flags[CCR_C] = carry;
    flags[CCR_V] = ovf;
    flags[CCR_Z] = (res == '0);
    flags[CCR_S] = res[MSB];
  end
endmodule

// File: rtl/alu_seq_dp.sv
module alu_seq_dp
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_N  = 8,
  parameter int PC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strb,
  input  logic [INSTR_W-1:0]       romData,
  input  logic [$clog2(REG_N)-1:0] dbgRegSel,
  output logic [PC_W-1:0]          pc,
  output logic [3:0]               ccr,
  output logic [DATA_W-1:0]        dbgRegData
);
  localparam int IDX_W = $clog2(REG_N);
  localparam int IMM_W = 4;

  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  rf [REG_N];
  logic [DATA_W-1:0]  opA, opB, resReg, aluRes;
  logic [3:0]         flagReg, aluFlags;
  logic               cinReg, cinSel;
  logic [DATA_W-1:0]  immExt, secondSrc;

  wire [3:0]       irOp     = ir[15:12];
  wire [IDX_W-1:0] irDst    = ir[9 +: IDX_W];
  wire [IDX_W-1:0] irSrcA   = ir[6 +: IDX_W];
  wire [IDX_W-1:0] irSrcB   = ir[0 +: IDX_W];
  wire             irImm    = ir[5];
  wire             irUseCry = ir[4];

  always_comb begin
    immExt    = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    secondSrc = irImm ? immExt : rf[irSrcB];
    if (irUseCry) cinSel = ccr[CCR_C];
    else          cinSel = (opcode_e'(irOp) == OP_SUB);
  end

  alu_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .op(irOp), .a(opA), .b(opB), .cin(cinReg),
    .res(aluRes), .flags(aluFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ir      <= '0;
      opA     <= '0;
      opB     <= '0;
      cinReg  <= 1'b0;
      resReg  <= '0;
      flagReg <= '0;
      ccr     <= '0;
      pc      <= '0;
    end else begin
      if (strb.loadIr) ir <= romData;
      if (strb.loadOps) begin
        opA    <= rf[irSrcA];
        opB    <= secondSrc;
        cinReg <= cinSel;
      end
      if (strb.loadRes) begin
        resReg  <= aluRes;
        flagReg <= aluFlags;
      end
      if (strb.writeCcr) ccr <= flagReg;
      if (strb.incPc)    pc  <= pc + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < REG_N; g++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             rf[g] <= '0;
        else if (strb.writeReg && irDst == g)  rf[g] <= resReg;
      end
    end
  endgenerate

  assign dbgRegData = rf[dbgRegSel];
endmodule

// File: rtl/alu_seq.sv
module alu_seq
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_N  = 8,
  parameter int PC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic [PC_W-1:0]          romAddr,
  input  logic [INSTR_W-1:0]       romData,
  output logic                     illegal,
  output logic [PC_W-1:0]          dbgPc,
  output logic [3:0]               dbgCcr,
  input  logic [$clog2(REG_N)-1:0] dbgRegSel,
  output logic [DATA_W-1:0]        dbgRegData
);
  strobes_t        strb;
  logic [PC_W-1:0] pc;

  alu_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchedOp(romData[15:12]),
    .strb(strb), .illegal(illegal)
  );

  alu_seq_dp #(.DATA_W(DATA_W), .REG_N(REG_N), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .romData(romData),
    .dbgRegSel(dbgRegSel), .pc(pc), .ccr(dbgCcr), .dbgRegData(dbgRegData)
  );

  assign romAddr = pc;
  assign dbgPc   = pc;
endmodule

// File: rtl/alu_seq_chk.sv
module alu_seq_chk
  import alu_seq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input strobes_t        strb,
  input logic            illegal,
  input logic [PC_W-1:0] dbgPc,
  input logic [3:0]      dbgCcr
);
  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (dbgPc != $past(dbgPc)) |-> (dbgPc == PC_W'($past(dbgPc) + 1'b1)));

  a_r8_pc_only_on_incr: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incPc |=> $stable(dbgPc));

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadIr, strb.loadOps, strb.loadRes,
              strb.writeCcr, strb.writeReg, strb.incPc}));

  a_r6_ccr_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeCcr |=> $stable(dbgCcr));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> illegal);

  a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> ($stable(dbgPc) && $stable(dbgCcr)));
endmodule

bind alu_seq alu_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .illegal(illegal),
  .dbgPc(dbgPc), .dbgCcr(dbgCcr)
);

// File: tb/alu_seq_tb.sv
module alu_seq_tb;
  localparam int PC_W = 8;
  localparam int ROM_N = 1 << PC_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [PC_W-1:0] romAddr;
  logic [15:0] romData;
  logic        illegal;
  logic [PC_W-1:0] dbgPc;
  logic [3:0]  dbgCcr;
  logic [2:0]  dbgRegSel = '0;
  logic [15:0] dbgRegData;

  logic [15:0] rom [ROM_N];
  logic [15:0] mReg [8];
  logic [3:0]  mCcr;
  int nTests = 0;
  int nFail  = 0;
  bit hung   = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) romData <= rom[romAddr];

  alu_seq u_dut (
    .clk(clk), .rstN(rstN), .romAddr(romAddr), .romData(romData),
    .illegal(illegal), .dbgPc(dbgPc), .dbgCcr(dbgCcr),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [15:0] val);
    dbgRegSel = 3'(idx);
    #1;
    val = dbgRegData;
  endtask

  // Reference model of one instruction (R1..R7)
  task automatic model(input logic [15:0] ins);
    logic [3:0]  op;
    logic [15:0] a, b, bEff, r;
    logic [16:0] s;
    logic cin, c, v;
    op = ins[15:12];
    a  = mReg[ins[8:6]];
    b  = ins[5] ? {{12{ins[3]}}, ins[3:0]} : mReg[ins[2:0]];
    c = 1'b0; v = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        bEff = (op == 4'd1) ? ~b : b;
        cin  = ins[4] ? mCcr[3] : (op == 4'd1);
        s = {1'b0, a} + {1'b0, bEff} + {16'd0, cin};
        r = s[15:0];
        c = s[16];
        v = (a[15] == bEff[15]) && (r[15] != a[15]);
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      default: r = a ^ b;
    endcase
    mCcr = {c, v, (r == 16'd0), r[15]};
    mReg[ins[11:9]] = r;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    mCcr = '0;
    check("R10", "pc in reset", 16'(dbgPc), 16'd0);
    check("R10", "ccr in reset", 16'(dbgCcr), 16'd0);
    check("R11", "romAddr in reset", 16'(romAddr), 16'd0);
    check("R9", "illegal in reset", 16'(illegal), 16'd0);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      readReg(i, v);
      check("R10", "reg in reset", v, 16'd0);
    end
    rstN = 1'b1;
  endtask

  task automatic runProgram(input int n);
    logic [PC_W-1:0] prev;
    logic [15:0] v;
    string tag;
    int cyc;
    doReset();
    prev = '0;
    for (int k = 0; k < n && !hung; k++) begin
      cyc = 0;
      while (dbgPc == prev && cyc < 60) begin
        @(negedge clk);
        cyc++;
      end
      if (cyc >= 60) begin
        hung = 1;
        nTests++; nFail++;
        $display("FAIL R8 watchdog: actual no pc step expected step");
        return;
      end
      prev = dbgPc;
      model(rom[k]);
      case (rom[k][15:12])
        4'd0: tag = "R3";
        4'd1: tag = "R4";
        default: tag = "R5";
      endcase
      check("R8", "cycles per instruction", 16'(cyc), 16'd7);
      check("R8", "pc step", 16'(dbgPc), 16'(k + 1));
      check(tag, "ccr {C,V,Z,S} (R6)", 16'(dbgCcr), 16'(mCcr));
      readReg(rom[k][11:9], v);
      check("R7", "destination register", v, mReg[rom[k][11:9]]);
    end
    repeat (25) @(negedge clk);
    check("R9", "illegal raised", 16'(illegal), 16'd1);
    check("R9", "pc frozen", 16'(dbgPc), 16'(n));
    check("R9", "ccr frozen", 16'(dbgCcr), 16'(mCcr));
    for (int i = 0; i < 8; i++) begin
      readReg(i, v);
      check("R9", "register frozen", v, mReg[i]);
    end
  endtask

  initial begin
    for (int i = 0; i < ROM_N; i++) rom[i] = 16'hF000;
    // Directed: addi chain and flag corners (R2, R3, R4, R5, R6)
    rom[0] = {4'd0, 3'd1, 3'd0, 1'b1, 1'b0, 4'h7};   // r1 = 0 + 7
    rom[1] = {4'd0, 3'd2, 3'd1, 1'b1, 1'b0, 4'hF};   // r2 = 7 + -1, C
    rom[2] = {4'd1, 3'd3, 3'd0, 1'b0, 1'b0, 4'h1};   // r3 = 0 - 7
    rom[3] = {4'd4, 3'd4, 3'd1, 1'b0, 1'b1, 4'h9};   // r4 = r1 ^ r1, bit3 ignored
    rom[4] = {4'd0, 3'd5, 3'd2, 1'b1, 1'b1, 4'h0};   // r5 = 6 + 0 + C(0)
    rom[5] = {4'd1, 3'd6, 3'd1, 1'b1, 1'b1, 4'h7};   // r6 = 7 - 7 with C
    rom[6] = {4'd2, 3'd7, 3'd3, 1'b1, 1'b1, 4'h8};   // and with sext imm
    rom[7] = {4'd3, 3'd0, 3'd3, 1'b0, 1'b0, 4'h1};   // or
    rom[8] = 16'h5000;
    runProgram(8);
    for (int p = 0; p < 6 && !hung; p++) begin
      for (int i = 0; i < 240; i++)
        rom[i] = {4'($urandom_range(0, 4)), 12'($urandom)};
      rom[240] = {4'($urandom_range(5, 15)), 12'($urandom)};
      runProgram(240);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    nTests++; nFail++;
    $display("FAIL R8 global watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule